// File: doc/BRIEF.md
# Chained Transmit Descriptor Walker

This block is the fetch side of a transmit DMA. Once started, it walks a list of four-word descriptors that sit in a memory behind a synchronous read/write port, with a read latency of one cycle. The first word carries the control flags. The second carries the byte count. The third carries the buffer address. The fourth carries a link to another descriptor.

The walker reads the first word of each descriptor. If the hardware-ownership flag is set, it reads the other three words. It then raises a one-cycle byte request that carries the buffer address, the length and the segment flags. Next it writes the first word back with ownership cleared, which returns the descriptor to software, and moves to the next descriptor.

When the walker finds a descriptor that software still owns, it raises an unavailable flag and parks. A poll-demand strobe makes it read the same descriptor again. Software clears the two status flags by writing ones to them.

Top module: `txdw_engine`

## Requirements
- R1: After reset the block makes no memory access, raises no request and both flags are 0. Until a start strobe arrives it stays idle, and a poll strobe while idle causes no memory access.
- R2: A start strobe while idle loads the descriptor pointer from `listBase`. The read of word 0 at that address happens in the cycle after the start cycle, and the byte request follows six cycles after the start cycle.
- R3: When word 0 has bit 31 (hardware owns) set, the block reads words 1, 2 and 3. It then raises `reqValid` for exactly one cycle, with the following fields:
  - `reqBufAddr` = word 2
  - `reqLen` = word 1 bits [LEN_W-1:0]
  - `reqFirst` = word 0 bit 28
  - `reqLast` = word 0 bit 29
- R4: In the cycle after `reqValid`, the block writes word 0 back to the descriptor's own address with bit 31 cleared and every other bit unchanged.
- R5: After the write-back, the next descriptor address is taken from word 3 when word 0 bit 20 (chain) is set. Otherwise it is the current address plus 4.
- R6: When word 0 has bit 31 clear, the block sets `txUnavailFlag`, suspends and makes no further memory access.
- R7: While suspended, a poll strobe makes the block read word 0 at the same address again. Poll and start strobes arriving while a descriptor is being processed have no effect.
- R8: A write-back of a descriptor with bit 30 (interrupt on completion) and bit 29 (last segment) both set sets `txIntrFlag`. Bit 30 without bit 29 does not set it.
- R9: `statClr` bit 0 clears `txIntrFlag` and bit 1 clears `txUnavailFlag`, each independently of the other. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start strobe; loads pointer from listBase when idle |
| pollDemand | input | 1 | Poll strobe; restarts a suspended walker |
| listBase | input | ADDR_W | Word address of the first descriptor |
| statClr | input | 2 | Write-1-to-clear: bit 0 interrupt flag, bit 1 unavailable flag |
| memRe | output | 1 | Descriptor memory read enable |
| memWe | output | 1 | Descriptor memory write enable |
| memAddr | output | ADDR_W | Descriptor memory word address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after memRe |
| reqValid | output | 1 | One-cycle byte request strobe |
| reqBufAddr | output | 32 | Buffer address of the request |
| reqLen | output | LEN_W | Byte count of the request |
| reqFirst | output | 1 | First-segment flag of the request |
| reqLast | output | 1 | Last-segment flag of the request |
| txIntrFlag | output | 1 | Completion interrupt status |
| txUnavailFlag | output | 1 | Descriptor-unavailable status |

## Verification
The discovery of a software-owned descriptor can coincide with software's write-1 clear of the unavailable flag. To provoke this, the bench pulses poll against a still-unowned descriptor. It then drives the clear exactly in the cycle the block re-checks ownership, which is two cycles after the poll is taken. The flag must read 1 afterwards, and the interrupt flag must be untouched by that clear. A cycle-by-cycle model also compares every request and write-back against queues built from the bench's own memory image.

// File: rtl/txdw_pkg.sv
package txdw_pkg;
  localparam int OWN_BIT    = 31;
  localparam int IC_BIT     = 30;
  localparam int LS_BIT     = 29;
  localparam int FS_BIT     = 28;
  localparam int CHAIN_BIT  = 20;
  localparam int DESC_WORDS = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_LEN, ST_BUF, ST_NEXT, ST_EMIT, ST_WBACK, ST_SUSP
  } walkState_t;

  typedef struct packed {
    logic       loadBase;
    logic       rd;
    logic       wr;
    logic [1:0] wordSel;
    logic       capW0;
    logic       capLen;
    logic       capBuf;
    logic       capNxt;
    logic       emit;
    logic       advance;
    logic       setUnavail;
  } ctlStrb_t;
endpackage

// File: rtl/txdw_ctrl.sv
module txdw_ctrl
  import txdw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     pollDemand,
  input  logic     ownSeen,
  output ctlStrb_t strb
);
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (startReq) begin
        strb.loadBase = 1'b1;
        nextState     = ST_FETCH;
      end
      ST_FETCH: begin
        strb.rd      = 1'b1;
        strb.wordSel = 2'd0;
        nextState    = ST_CHECK;
      end
      ST_CHECK: begin
        strb.capW0 = 1'b1;
        if (ownSeen) begin
          strb.rd      = 1'b1;
          strb.wordSel = 2'd1;
          nextState    = ST_LEN;
        end else begin
          strb.setUnavail = 1'b1;
          nextState       = ST_SUSP;
        end
      end
      ST_LEN: begin
        strb.capLen  = 1'b1;
        strb.rd      = 1'b1;
        strb.wordSel = 2'd2;
        nextState    = ST_BUF;
      end
      ST_BUF: begin
        strb.capBuf  = 1'b1;
        strb.rd      = 1'b1;
        strb.wordSel = 2'd3;
        nextState    = ST_NEXT;
      end
      ST_NEXT: begin
        strb.capNxt = 1'b1;
        nextState   = ST_EMIT;
      end
      ST_EMIT: begin
        strb.emit = 1'b1;
        nextState = ST_WBACK;
      end
      ST_WBACK: begin
        strb.wr      = 1'b1;
        strb.wordSel = 2'd0;
        strb.advance = 1'b1;
        nextState    = ST_FETCH;
      end
      ST_SUSP: if (pollDemand) nextState = ST_FETCH;
      default: nextState = ST_IDLE;
    endcase
  end

  // R7
  poll_refetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && pollDemand) |=> (strb.rd && strb.wordSel == 2'd0));

  // R6
  suspend_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && !pollDemand) |=> !(strb.rd || strb.wr));
endmodule

// File: rtl/txdw_path.sv
module txdw_path
  import txdw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] listBase,
  input  logic [1:0]        statClr,
  input  logic [31:0]       memRdata,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              ownSeen,
  output logic              reqValid,
  output logic [31:0]       reqBufAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic              reqFirst,
  output logic              reqLast,
  output logic              txIntrFlag,
  output logic              txUnavailFlag
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_WORDS);

  logic [ADDR_W-1:0] curPtr;
  logic [31:0]       w0Q, bufQ, nxtQ;
  logic [LEN_W-1:0]  lenQ;
  logic              setIntr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr <= '0;
      w0Q    <= '0;
      bufQ   <= '0;
      nxtQ   <= '0;
      lenQ   <= '0;
    end else begin
      if (strb.loadBase)    curPtr <= listBase;
      else if (strb.advance) curPtr <= w0Q[CHAIN_BIT] ? nxtQ[ADDR_W-1:0] : curPtr + STRIDE;
      if (strb.capW0)  w0Q  <= memRdata;
      if (strb.capLen) lenQ <= memRdata[LEN_W-1:0];
      if (strb.capBuf) bufQ <= memRdata;
      if (strb.capNxt) nxtQ <= memRdata;
    end
  end

  assign setIntr = strb.wr && w0Q[IC_BIT] && w0Q[LS_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txIntrFlag    <= 1'b0;
      txUnavailFlag <= 1'b0;
    end else begin
      txIntrFlag    <= (txIntrFlag    && !statClr[0]) || setIntr;
      txUnavailFlag <= (txUnavailFlag && !statClr[1]) || strb.setUnavail;
    end
  end

  assign ownSeen    = memRdata[OWN_BIT];
  assign memRe      = strb.rd;
  assign memWe      = strb.wr;
  assign memAddr    = curPtr + ADDR_W'(strb.wordSel);
  assign reqValid   = strb.emit;
  assign reqBufAddr = bufQ;
  assign reqLen     = lenQ;
  assign reqFirst   = w0Q[FS_BIT];
  assign reqLast    = w0Q[LS_BIT];

  always_comb begin
    memWdata          = w0Q;
    memWdata[OWN_BIT] = 1'b0;
  end

  // R4
  wb_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> memWe);

  // R4
  wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !memWdata[OWN_BIT]);

  // R9
  unavail_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setUnavail |=> txUnavailFlag);

  // R8
  intr_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txIntrFlag) |-> $past(memWe));

  // R1
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));
endmodule

// File: rtl/txdw_engine.sv
module txdw_engine
  import txdw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              pollDemand,
  input  logic [ADDR_W-1:0] listBase,
  input  logic [1:0]        statClr,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              reqValid,
  output logic [31:0]       reqBufAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic              reqFirst,
  output logic              reqLast,
  output logic              txIntrFlag,
  output logic              txUnavailFlag
);
  ctlStrb_t strb;
  logic     ownSeen;

  txdw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pollDemand(pollDemand),
    .ownSeen(ownSeen), .strb(strb)
  );

  txdw_path #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .listBase(listBase), .statClr(statClr),
    .memRdata(memRdata), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .ownSeen(ownSeen), .reqValid(reqValid),
    .reqBufAddr(reqBufAddr), .reqLen(reqLen), .reqFirst(reqFirst), .reqLast(reqLast),
    .txIntrFlag(txIntrFlag), .txUnavailFlag(txUnavailFlag)
  );
endmodule

// File: tb/txdw_engine_bench.sv
module txdw_engine_bench;
  localparam int AW = 16;
  localparam int LW = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0, pollDemand = 1'b0;
  logic [AW-1:0] listBase = '0;
  logic [1:0]    statClr = 2'b00;
  logic          memRe, memWe, reqValid, reqFirst, reqLast, txIntrFlag, txUnavailFlag;
  logic [AW-1:0] memAddr;
  logic [31:0]   memWdata, memRdata, reqBufAddr;
  logic [LW-1:0] reqLen;
  logic [31:0]   mem [64];

  int errs = 0, checks = 0;
  int expReqAddr[$], expReqLen[$], expReqFl[$], expWbAddr[$];
  logic [31:0] expWbData[$];
  bit   quietWatch = 1'b0;
  int   quietHits = 0;

  always #10 clk = ~clk;

  txdw_engine #(.ADDR_W(AW), .LEN_W(LW)) u_txdw_engine (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pollDemand(pollDemand),
    .listBase(listBase), .statClr(statClr), .memRe(memRe), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .reqValid(reqValid), .reqBufAddr(reqBufAddr), .reqLen(reqLen),
    .reqFirst(reqFirst), .reqLast(reqLast), .txIntrFlag(txIntrFlag),
    .txUnavailFlag(txUnavailFlag)
  );

  always @(posedge clk) begin
    if (memRe) memRdata <= mem[memAddr[5:0]];
    if (memWe) mem[memAddr[5:0]] <= memWdata;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // behavioural model: derive expected request and write-back from the memory image
  task automatic expectDesc(int a);
    logic [31:0] w0 = mem[a];
    expReqAddr.push_back(int'(mem[a+2]));
    expReqLen.push_back(int'(mem[a+1] & 32'h1FFF));
    expReqFl.push_back({w0[29], w0[28]});
    expWbAddr.push_back(a);
    expWbData.push_back(w0 & 32'h7FFF_FFFF);
  endtask

  // per-clock comparison against the model queues
  always @(negedge clk) if (rstN) begin
    if (quietWatch && (memRe || memWe)) quietHits++;
    if (reqValid) begin
      if (expReqAddr.size() == 0) chk("R3 unexpected request", 32'd1, 32'd0);
      else begin
        chk("R3 bufAddr", reqBufAddr, expReqAddr.pop_front());
        chk("R3 len", 32'(reqLen), expReqLen.pop_front());
        chk("R3 last/first", {30'd0, reqLast, reqFirst}, expReqFl.pop_front());
      end
    end
    if (memWe) begin
      if (expWbAddr.size() == 0) chk("R4 unexpected write-back", 32'd1, 32'd0);
      else begin
        chk("R4/R5 wb addr", 32'(memAddr), expWbAddr.pop_front());
        chk("R4 wb data", memWdata, expWbData.pop_front());
      end
    end
  end

  task automatic pulse(ref logic sig);
    @(posedge clk); #1 sig = 1'b1;
    @(posedge clk); #1 sig = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    mem[0]  = 32'hB010_0000; mem[1]  = 32'd60;   mem[2]  = 32'h1000; mem[3]  = 32'd16;
    mem[16] = 32'hD010_0000; mem[17] = 32'd1514; mem[18] = 32'h2000; mem[19] = 32'd8;
    mem[8]  = 32'hA000_0000; mem[9]  = 32'd7;    mem[10] = 32'h3000; mem[11] = 32'd40;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset memRe", 32'(memRe), 0);
    chk("R1 reset reqValid", 32'(reqValid), 0);
    chk("R1 reset flags", {30'd0, txIntrFlag, txUnavailFlag}, 0);

    quietWatch = 1'b1;
    pulse(pollDemand);
    repeat (4) @(negedge clk);
    quietWatch = 1'b0;
    chk("R1 poll while idle", 32'(quietHits), 0);

    // run A: 0 -> 16 -> 8 (chain), 8 -> 12 (sequential), 12 unowned
    expectDesc(0); expectDesc(16); expectDesc(8);
    listBase = 16'd0;
    pulse(startReq);
    @(negedge clk);
    chk("R2 first read", {memRe, 15'd0, memAddr}, {1'b1, 31'd0});
    repeat (4) @(negedge clk);
    chk("R2 no request yet", 32'(reqValid), 0);
    @(negedge clk);
    chk("R2 request latency", 32'(reqValid), 1);
    pulse(startReq);
    pulse(pollDemand);
    repeat (40) @(negedge clk);
    chk("R6 unavailable set", 32'(txUnavailFlag), 1);
    chk("R8 IC without LS", 32'(txIntrFlag), 0);
    chk("R4 mem0", mem[0], 32'h3010_0000);
    chk("R4 mem16", mem[16], 32'h5010_0000);
    chk("R5 queues drained", 32'(expReqAddr.size() + expWbAddr.size()), 0);
    quietHits = 0; quietWatch = 1'b1;
    repeat (10) @(negedge clk);
    quietWatch = 1'b0;
    chk("R6 no access while suspended", 32'(quietHits), 0);

    statClr = 2'b10; @(posedge clk); #1 statClr = 2'b00;
    @(negedge clk);
    chk("R9 clear unavailable", 32'(txUnavailFlag), 0);
    chk("R9 intr untouched", 32'(txIntrFlag), 0);

    // run B: software hands 12 over, chained back to 0 (now software-owned)
    mem[12] = 32'hF010_0000; mem[13] = 32'd100; mem[14] = 32'h4000; mem[15] = 32'd0;
    expectDesc(12);
    pulse(pollDemand);
    repeat (25) @(negedge clk);
    chk("R7 resumed write-back", mem[12], 32'h7010_0000);
    chk("R8 IC with LS", 32'(txIntrFlag), 1);
    chk("R6 unavailable again", 32'(txUnavailFlag), 1);
    chk("R7 queues drained", 32'(expReqAddr.size() + expWbAddr.size()), 0);

    statClr = 2'b10; @(posedge clk); #1 statClr = 2'b00;
    pulse(pollDemand);
    @(posedge clk); #1 statClr = 2'b10;
    @(posedge clk); #1 statClr = 2'b00;
    @(negedge clk);
    chk("R9 set wins over clear", 32'(txUnavailFlag), 1);
    chk("R9 other flag kept", 32'(txIntrFlag), 1);

    statClr = 2'b01; @(posedge clk); #1 statClr = 2'b00;
    @(negedge clk);
    chk("R9 clear intr", {30'd0, txIntrFlag, txUnavailFlag}, 32'd1);
    summary();
  end
endmodule